// File: doc/BRIEF.md
# Word-Serial Scaled Accumulate Engine for Multi-Word Integers

The engine takes an unsigned integer of `len` 16-bit words and multiplies every word by a 16-bit scalar `k`, carrying the upper half of each partial result into the next word. It runs in one of three modes. The first writes the scaled array out. The second adds the scaled array into a destination array. The third subtracts the scaled array from a destination array. Arrays live in a word-addressed memory with the least significant word at the lowest address. The engine walks the array upwards from word 0 through one single-port memory port with a read latency of one cycle. That port has no stall signal, so the memory must accept a request in every cycle.

A job starts through a command channel with valid/ready handshake. The command carries the mode, the source base address, the destination base address, the length and `k`. `cmd_ready` is high only while the engine is idle. A command that is held with `cmd_valid` while the engine is busy waits: it is back-pressured and is not lost. When the job finishes, `done` pulses for one cycle. In that cycle `result` carries the final carry word (add and multiply modes) or borrow word (subtract mode). The result side has no back-pressure, so the consumer must take `result` in the `done` cycle. The length is carried as `len-1` in a 16-bit down-counter, so lengths from 1 to 65536 words are legal.

Top module: `bignum_mac_engine`

## Requirements
- R1: `cmd_ready` is high exactly when the engine is idle, and a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. From the cycle after acceptance through the `done` cycle, `busy` is high and `cmd_ready` is low. In the cycle after `done`, the engine is idle again.
- R2: Mode 2'b00 (scale): with A the source value and P = A·k, destination words 0..len-1 receive words 0..len-1 of P. Destination word len receives the top word of P, and `result` equals that top word.
- R3: Mode 2'b01 (scale-add): with D the old destination value, destination words 0..len-1 receive the low 16·len bits of D + A·k. `result` is (D + A·k) >> 16·len.
- R4: Mode 2'b10 (scale-subtract): destination words 0..len-1 receive (D − A·k) mod 2^(16·len). `result` is the borrow word b, the smallest b ≥ 0 with D + b·2^(16·len) ≥ A·k.
- R5: Memory outside the written destination words is left unchanged. The written words are 0..len in mode 2'b00 and 0..len-1 in the other modes. This includes the source array and destination word len in the accumulate modes.
- R6: A length of 0 or mode 2'b11 is rejected. `done` and `err` are both high in the first cycle after acceptance, `result` is 0, and no memory access is made.
- R7: `done` is a single-cycle pulse. It is first seen 2·len+1 cycles after the accepting edge in mode 2'b00, and 3·len cycles after it in the accumulate modes. The memory operation just before a successful `done` is a write.
- R8: The running carry never needs more than 16 bits, even with k = 16'hFFFF and all-ones data, so `result` is exact in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command will be taken |
| cmd_mode | input | 2 | 00 scale, 01 scale-add, 10 scale-subtract, 11 illegal |
| cmd_src | input | ADDR_W | Source array base address |
| cmd_dst | input | ADDR_W | Destination array base address |
| cmd_len | input | CNT_W+1 | Word count, 1 to 2^CNT_W |
| cmd_k | input | WORD_W | Scalar multiplier |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejected command, valid with done |
| result | output | WORD_W | Final carry or borrow word, valid with done |
| mem_en | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | WORD_W | Write data |
| mem_rdata | input | WORD_W | Read data, one cycle after a read request |

## Verification
Some behaviours are checked on every cycle by the assertions. The carry register never needs its seventeenth bit. An accepted command always leaves the engine busy. `done` never lasts two cycles. A successful finish is always preceded by a write, and a rejected command never reaches memory. The arithmetic itself can only be shown by the bench's scenarios. The bench sweeps every mode over lengths 1 to 4, several scalars, and hashed or all-ones data, and compares the whole memory and the returned word against products computed as wide integers. Completion latency and handshake timing are also checked there.

// File: rtl/bnmac_pkg.sv
package bnmac_pkg;
  typedef enum logic [1:0] {
    OP_SCALE = 2'd0,
    OP_ADD   = 2'd1,
    OP_SUB   = 2'd2,
    OP_BAD   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSRC,
    ST_RDST,
    ST_WRT,
    ST_WTOP,
    ST_FIN
  } st_e;
endpackage

// File: rtl/bnmac_step.sv
module bnmac_step
  import bnmac_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  op_e               op,
  input  logic [WORD_W-1:0] src,
  input  logic [WORD_W-1:0] k,
  input  logic [WORD_W-1:0] dst,
  input  logic [WORD_W:0]   cin,
  output logic [WORD_W-1:0] res,
  output logic [WORD_W:0]   cout
);
  localparam int PW = 2 * WORD_W + 1;

  logic [2*WORD_W-1:0] prod;
  logic [PW-1:0]       term;
  logic [PW-1:0]       acc;
  logic [WORD_W:0]     diff;

  assign prod = (2*WORD_W)'(src) * (2*WORD_W)'(k);
  assign term = {1'b0, prod} + PW'(cin);
  assign acc  = term + PW'(dst);
  assign diff = {1'b0, dst} - {1'b0, term[WORD_W-1:0]};

  always_comb begin
    case (op)
      OP_ADD: begin
        res  = acc[WORD_W-1:0];
        cout = acc[PW-1:WORD_W];
      end
      OP_SUB: begin
        res  = diff[WORD_W-1:0];
        cout = term[PW-1:WORD_W] + (WORD_W+1)'(diff[WORD_W]);
      end
      default: begin
        res  = term[WORD_W-1:0];
        cout = term[PW-1:WORD_W];
      end
    endcase
  end
endmodule

// File: rtl/bnmac_datapath.sv
module bnmac_datapath
  import bnmac_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic              load,
  input  logic [WORD_W-1:0] k_in,
  input  logic              capture,
  input  logic              step,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] carry_lo
);
  logic [WORD_W-1:0] k_q;
  logic [WORD_W-1:0] src_q;
  logic [WORD_W:0]   carry_q;
  logic [WORD_W-1:0] src_word;
  logic [WORD_W:0]   cout;

  // scale mode has no destination read, so the source word arrives in the write cycle
  assign src_word = (op == OP_SCALE) ? rdata : src_q;

  bnmac_step #(.WORD_W(WORD_W)) u_step (
    .op   (op),
    .src  (src_word),
    .k    (k_q),
    .dst  (rdata),
    .cin  (carry_q),
    .res  (wdata),
    .cout (cout)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_q     <= '0;
      src_q   <= '0;
      carry_q <= '0;
    end else begin
      if (load) begin
        k_q     <= k_in;
        carry_q <= '0;
      end else if (step) begin
        carry_q <= cout;
      end
      if (capture) src_q <= rdata;
    end
  end

  assign carry_lo = carry_q[WORD_W-1:0];

  // R8
  carry_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !cout[WORD_W]);
endmodule

// File: rtl/bnmac_seq.sv
module bnmac_seq
  import bnmac_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_mode,
  input  logic [ADDR_W-1:0] cmd_src,
  input  logic [ADDR_W-1:0] cmd_dst,
  input  logic [CNT_W:0]    cmd_len,
  input  logic [WORD_W-1:0] step_wdata,
  input  logic [WORD_W-1:0] carry_lo,
  output logic              cmd_ready,
  output logic              busy,
  output logic              done,
  output logic              err,
  output op_e               op,
  output logic              load,
  output logic              capture,
  output logic              step,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);
  localparam int LEN_W = CNT_W + 1;

  st_e               st;
  op_e               op_q;
  logic [ADDR_W-1:0] src_p;
  logic [ADDR_W-1:0] dst_p;
  logic [CNT_W-1:0]  cnt_q;
  logic              err_q;
  logic              accept;
  logic              reject;
  logic [LEN_W-1:0]  len_m1;

  assign accept = cmd_valid && (st == ST_IDLE);
  assign reject = (cmd_len == '0) || (cmd_mode == 2'b11);
  assign len_m1 = cmd_len - LEN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      op_q  <= OP_SCALE;
      src_p <= '0;
      dst_p <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          op_q  <= op_e'(cmd_mode);
          src_p <= cmd_src;
          dst_p <= cmd_dst;
          cnt_q <= len_m1[CNT_W-1:0];
          err_q <= reject;
          st    <= reject ? ST_FIN : ST_RSRC;
        end
        ST_RSRC: st <= (op_q == OP_SCALE) ? ST_WRT : ST_RDST;
        ST_RDST: st <= ST_WRT;
        ST_WRT: begin
          src_p <= src_p + ADDR_W'(1);
          dst_p <= dst_p + ADDR_W'(1);
          if (cnt_q == '0) begin
            st <= (op_q == OP_SCALE) ? ST_WTOP : ST_FIN;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
            st    <= ST_RSRC;
          end
        end
        ST_WTOP: st <= ST_FIN;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign op        = op_q;
  assign load      = accept;
  assign capture   = (st == ST_RDST);
  assign step      = (st == ST_WRT);
  assign cmd_ready = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);
  assign done      = (st == ST_FIN);
  assign err       = done && err_q;

  assign mem_en    = (st == ST_RSRC) || (st == ST_RDST) || (st == ST_WRT) || (st == ST_WTOP);
  assign mem_we    = (st == ST_WRT) || (st == ST_WTOP);
  assign mem_addr  = (st == ST_RSRC) ? src_p : dst_p;
  assign mem_wdata = (st == ST_WTOP) ? carry_lo : step_wdata;

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && !cmd_ready));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  fin_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> $past(mem_we));

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> $past(!mem_en));
endmodule

// File: rtl/bignum_mac_engine.sv
module bignum_mac_engine
  import bnmac_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_mode,
  input  logic [ADDR_W-1:0] cmd_src,
  input  logic [ADDR_W-1:0] cmd_dst,
  input  logic [CNT_W:0]    cmd_len,
  input  logic [WORD_W-1:0] cmd_k,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] result,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  op_e               op;
  logic              load;
  logic              capture;
  logic              step;
  logic [WORD_W-1:0] step_wdata;
  logic [WORD_W-1:0] carry_lo;

  bnmac_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_mode   (cmd_mode),
    .cmd_src    (cmd_src),
    .cmd_dst    (cmd_dst),
    .cmd_len    (cmd_len),
    .step_wdata (step_wdata),
    .carry_lo   (carry_lo),
    .cmd_ready  (cmd_ready),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .op         (op),
    .load       (load),
    .capture    (capture),
    .step       (step),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );

  bnmac_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .load     (load),
    .k_in     (cmd_k),
    .capture  (capture),
    .step     (step),
    .rdata    (mem_rdata),
    .wdata    (step_wdata),
    .carry_lo (carry_lo)
  );

  assign result = carry_lo;
endmodule

// File: tb/bignum_mac_engine_test.sv
`timescale 1ns/1ps
module bignum_mac_engine_test;
  localparam int SRC = 2;
  localparam int DST = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_mode = 2'b00;
  logic [15:0] cmd_src = '0;
  logic [15:0] cmd_dst = '0;
  logic [16:0] cmd_len = '0;
  logic [15:0] cmd_k = '0;
  logic        busy, done, err;
  logic [15:0] result;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;

  logic [15:0] mem  [64];
  logic [15:0] orig [64];
  logic [15:0] expm [64];

  int checks = 0;
  int fails  = 0;
  int run_id = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  bignum_mac_engine uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len),
    .cmd_k(cmd_k), .busy(busy), .done(done), .err(err), .result(result),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[5:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "WDG", "watchdog expired", 32'(cycles), 32'd150000);
      finish_up();
    end
  end

  task automatic run(input int mode, input int len, input logic [15:0] k, input int seed);
    logic [127:0] a, d, p, e, b;
    int n, exp_lat, lat;
    logic [15:0] exp_res, got_res;
    bit exp_err, got_err, hs_ok;
    string rq;
    run_id++;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      mem[i]  = (seed == 1) ? 16'hFFFF : 16'((i * 40503 + run_id * 7919) ^ (i << 5));
      orig[i] = mem[i];
      expm[i] = mem[i];
    end
    a = '0; d = '0; n = 16 * len;
    for (int i = 0; i < len; i++) begin
      a = a | (128'(orig[SRC+i]) << (16 * i));
      d = d | (128'(orig[DST+i]) << (16 * i));
    end
    p = a * 128'(k);
    exp_err = 1'b0; exp_res = '0;
    rq = (mode == 0) ? "R2" : (mode == 1) ? "R3" : "R4";
    if (len == 0 || mode == 3) begin
      exp_err = 1'b1; exp_lat = 0; rq = "R6";
    end else if (mode == 0) begin
      for (int i = 0; i <= len; i++) expm[DST+i] = p[16*i +: 16];
      exp_res = p[n +: 16]; exp_lat = 2 * len + 1;
    end else if (mode == 1) begin
      e = d + p;
      for (int i = 0; i < len; i++) expm[DST+i] = e[16*i +: 16];
      exp_res = e[n +: 16]; exp_lat = 3 * len;
    end else begin
      if (p <= d) begin b = '0; e = d - p; end
      else begin
        b = (p - d + (128'd1 << n) - 128'd1) >> n;
        e = d + (b << n) - p;
      end
      for (int i = 0; i < len; i++) expm[DST+i] = e[16*i +: 16];
      exp_res = b[15:0]; exp_lat = 3 * len;
    end
    if (seed == 1 && k == 16'hFFFF && !exp_err) rq = "R8";
    cmd_valid = 1'b1; cmd_mode = 2'(mode); cmd_src = 16'(SRC); cmd_dst = 16'(DST);
    cmd_len = 17'(len); cmd_k = k;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 0; hs_ok = 1'b1;
    while (!done && lat < 1000) begin
      if (!busy || cmd_ready) hs_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    got_res = result; got_err = err;
    chk(hs_ok && busy && !cmd_ready, "R1", "busy/ready while running", {30'd0, busy, cmd_ready}, 32'd2);
    chk(lat == exp_lat, "R7", "done latency", 32'(lat), 32'(exp_lat));
    chk(got_err == exp_err, "R6", "err flag", 32'(got_err), 32'(exp_err));
    chk(got_res == exp_res, rq, "result word", 32'(got_res), 32'(exp_res));
    @(negedge clk);
    chk(!done && !busy && cmd_ready, "R1", "idle after done", {29'd0, done, busy, cmd_ready}, 32'd1);
    for (int i = 0; i < 64; i++) begin
      bit inside_dst;
      inside_dst = !exp_err && i >= DST && i < DST + len + ((mode == 0) ? 1 : 0);
      chk(mem[i] == expm[i], inside_dst ? rq : "R5", $sformatf("mem[%0d]", i),
          32'(mem[i]), 32'(expm[i]));
    end
  endtask

  initial begin
    logic [15:0] ks [5];
    ks[0] = 16'h0000; ks[1] = 16'h0001; ks[2] = 16'hFFFF; ks[3] = 16'h8001; ks[4] = 16'h1234;
    repeat (3) @(negedge clk);
    chk(!busy && !done && cmd_ready && !mem_en, "R1", "reset state",
        {28'd0, busy, done, cmd_ready, mem_en}, 32'd2);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 3; m++)
      for (int l = 1; l <= 4; l++)
        for (int ki = 0; ki < 5; ki++)
          for (int s = 0; s < 2; s++)
            run(m, l, ks[ki], s);
    for (int m = 0; m < 3; m++) run(m, 0, 16'h1234, 0);
    run(3, 2, 16'h0101, 0);
    run(3, 0, 16'hFFFF, 1);
    finish_up();
  end
endmodule